// File: doc/BRIEF.md
# Burst-Access Byte Register Bank

This block is a 256-address, byte-wide register bank for a host that sends short transactions. Each transaction is one command: a direction, a start address and a count of extra bytes. It then moves `cmd_len + 1` data bytes over a streaming channel, one for each consecutive address. The address counter wraps from 0xFF to 0x00. Every byte is decoded on its own, so a single burst can cross into registers of several kinds. The kinds are plain storage, write-only storage, live inputs, an event-flag register, a pulse-only control register and absent addresses.

Addresses below `POOL_DEPTH` (0x60 by default) exist and the rest do not. Most existing addresses are byte flops in a common pool. Four addresses are not pool storage:

- **Event flags (0x02):** two flags that sideband inputs set and a host write acknowledges.
- **Pulse control (0x20):** a write produces one-cycle pulses and nothing is stored.
- **Live value (0x27):** the read value is taken from an input port.
- **Write-only store (0x3D):** the byte is kept but reads back as zero.

Pool byte 0x24 is the watchdog timeout. The value is copied into a working limit only when the watchdog is started.

All three data-carrying channels use valid/ready:

- **Commands:** a command is taken on a cycle where `cmd_valid` and `cmd_ready` are both high.
- **Write data:** a byte is taken on a cycle where `wr_valid` and `wr_ready` are both high.
- **Read data:** the bank holds `rd_valid` and `rd_data` steady until `rd_ready` is seen. While a byte is held, no further byte is fetched.

Top module: `regbank_top`

## Requirements
- R1: A command is accepted on a clock edge where `cmd_valid` and `cmd_ready` are both high. It moves `cmd_len + 1` bytes at consecutive addresses starting at `cmd_addr`. `cmd_ready` is high only when no burst is active and no read byte is waiting, and `wr_ready` is high only during a write burst.
- R2: The burst address wraps from 0xFF to 0x00 and keeps applying each address's own kind.
- R3: Plain pool registers below 0x60 store each written byte and return it on read. Read data is registered. A byte fetched at an edge appears with `rd_valid` after that edge and stays unchanged while `rd_ready` is low.
- R4: Addresses 0x60 to 0xFF read as 0xFF. Writes to them change no register, including pool bytes whose low address bits match.
- R5: Address 0x27 is read-only and returns `live_in` as sampled at the fetch edge. Writes to it are dropped and do not disturb neighbouring bytes.
- R6: Address 0x02 holds two flags in bits [1:0]. Bit 0 is set by `evt_set[0]` (clock defaulted) and bit 1 by `evt_set[1]` (watchdog reset). Writing a 1 to a bit clears it, and writing a 0 leaves it. A set and a clear of the same bit on the same edge leave the bit set. Bits [7:2] read 0.
- R7: During reset the event flags load 3 if `rst_wdog_cause` is high, else 0. All pool bytes, `rd_valid`, `pwr_pulse` and `wdog_limit` clear.
- R8: A byte written to 0x20 drives its low four bits onto `pwr_pulse` for exactly the one cycle after the write edge. The upper four bits are discarded and nothing is stored.
- R9: Reads of the write-only addresses 0x20 and 0x3D return 0x00.
- R10: `wdog_start` copies pool byte 0x24 into `wdog_limit`. Later writes to 0x24 leave `wdog_limit` unchanged until the next start. `wdog_enable` is high exactly when `wdog_limit` is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_wdog_cause | input | 1 | High during reset when the reset came from the watchdog |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | 8 | First address of the burst |
| cmd_len | input | 8 | Number of bytes after the first |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte can be taken |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte held |
| rd_ready | input | 1 | Host takes the read byte |
| rd_data | output | 8 | Read byte |
| live_in | input | 8 | Live value returned at 0x27 |
| evt_set | input | 2 | Event flag set pulses |
| pwr_pulse | output | 4 | One-cycle power-control pulses |
| wdog_start | input | 1 | Watchdog (re)start strobe |
| wdog_limit | output | 8 | Timeout latched at the last start |
| wdog_enable | output | 1 | Latched timeout is non-zero |

## Verification
Each result has a fixed due time:

- A write byte takes effect at the edge where it is taken.
- `pwr_pulse` shows that byte's low four bits in the following cycle only.
- `wdog_limit` moves in the cycle after the edge that sees `wdog_start`.
- A read byte is fetched on the first edge after command acceptance, or after the previous byte left, and is held from then on.

The bench drives every input just after a falling edge and reads every output at the following falling edge. Each check therefore lands on the first cycle a change can show. Expected read bytes are queued when a read is issued, and a monitor compares each one in the cycle its handshake completes. This holds under both steady and random `rd_ready`.

// File: rtl/regbank_pkg.sv
package regbank_pkg;

  localparam int unsigned EVT_W   = 2;
  localparam int unsigned PULSE_W = 4;

  localparam int unsigned EVT_ADDR   = 32'h02;
  localparam int unsigned PULSE_ADDR = 32'h20;
  localparam int unsigned WDOG_ADDR  = 32'h24;
  localparam int unsigned LIVE_ADDR  = 32'h27;
  localparam int unsigned WONLY_ADDR = 32'h3D;

  typedef enum logic [2:0] {
    K_POOL, K_EVENT, K_PULSE, K_LIVE, K_WONLY, K_ABSENT
  } reg_kind_e;

  typedef enum logic [1:0] {SQ_IDLE, SQ_WRITE, SQ_READ} seq_state_e;

  function automatic reg_kind_e kind_of(input int unsigned a, input int unsigned depth);
    if (a >= depth)            return K_ABSENT;
    else if (a == EVT_ADDR)    return K_EVENT;
    else if (a == PULSE_ADDR)  return K_PULSE;
    else if (a == LIVE_ADDR)   return K_LIVE;
    else if (a == WONLY_ADDR)  return K_WONLY;
    else                       return K_POOL;
  endfunction

endpackage

// File: rtl/regbank_seq.sv
module regbank_seq
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [ADDR_W-1:0] cmd_len,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_we,
  output logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] fetch_byte
);

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] left_q;
  logic              rd_valid_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              fetch;
  logic              beat;

  assign cmd_ready = (state_q == SQ_IDLE) && !rd_valid_q;
  assign wr_ready  = (state_q == SQ_WRITE);
  assign fetch     = (state_q == SQ_READ) && (!rd_valid_q || rd_ready);
  assign acc_we    = wr_valid && wr_ready;
  assign beat      = acc_we || fetch;
  assign acc_addr  = addr_q;
  assign acc_wdata = wr_data;
  assign rd_valid  = rd_valid_q;
  assign rd_data   = rd_data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      addr_q  <= '0;
      left_q  <= '0;
    end else if (state_q == SQ_IDLE) begin
      if (cmd_valid && cmd_ready) begin
        addr_q  <= cmd_addr;
        left_q  <= cmd_len;
        state_q <= cmd_write ? SQ_WRITE : SQ_READ;
      end
    end else if (beat) begin
      addr_q <= addr_q + 1'b1;
      if (left_q == '0) state_q <= SQ_IDLE;
      else              left_q  <= left_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid_q <= 1'b0;
      rd_data_q  <= '0;
    end else if (fetch) begin
      rd_valid_q <= 1'b1;
      rd_data_q  <= fetch_byte;
    end else if (rd_ready) begin
      rd_valid_q <= 1'b0;
    end
  end

endmodule

// File: rtl/regbank_store.sv
module regbank_store
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POOL_DEPTH = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_wdog_cause,
  input  logic [ADDR_W-1:0]  acc_addr,
  input  logic               acc_we,
  input  logic [DATA_W-1:0]  acc_wdata,
  output logic [DATA_W-1:0]  rd_byte,
  input  logic [DATA_W-1:0]  live_in,
  input  logic [EVT_W-1:0]   evt_set,
  output logic [PULSE_W-1:0] pwr_pulse,
  input  logic               wdog_start,
  output logic [DATA_W-1:0]  wdog_limit,
  output logic               wdog_enable
);

  localparam int unsigned IDX_W = $clog2(POOL_DEPTH);

  reg_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic              wr_pool;
  logic [DATA_W-1:0] pool_q [POOL_DEPTH];
  logic [EVT_W-1:0]  evt_q;
  logic [EVT_W-1:0]  evt_keep;

  assign kind    = kind_of(32'(acc_addr), POOL_DEPTH);
  assign idx     = acc_addr[IDX_W-1:0];
  assign wr_pool = acc_we && (kind == K_POOL || kind == K_WONLY);

  for (genvar i = 0; i < POOL_DEPTH; i++) begin : g_pool
    always_ff @(posedge clk) begin
      if (!rst_n)                             pool_q[i] <= '0;
      else if (wr_pool && idx == IDX_W'(i))  pool_q[i] <= acc_wdata;
    end
  end

  assign evt_keep = (acc_we && kind == K_EVENT) ? (evt_q & ~acc_wdata[EVT_W-1:0]) : evt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      evt_q      <= rst_wdog_cause ? '1 : '0;
      pwr_pulse  <= '0;
      wdog_limit <= '0;
    end else begin
      evt_q     <= evt_keep | evt_set;
      pwr_pulse <= (acc_we && kind == K_PULSE) ? acc_wdata[PULSE_W-1:0] : '0;
      if (wdog_start) wdog_limit <= pool_q[WDOG_ADDR];
    end
  end

  assign wdog_enable = |wdog_limit;

  always_comb begin
    unique case (kind)
      K_ABSENT:         rd_byte = '1;
      K_EVENT:          rd_byte = DATA_W'(evt_q);
      K_PULSE, K_WONLY: rd_byte = '0;
      K_LIVE:           rd_byte = live_in;
      default:          rd_byte = pool_q[idx];
    endcase
  end

endmodule

// File: rtl/regbank_top.sv
module regbank_top
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned POOL_DEPTH = 96
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rst_wdog_cause,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [ADDR_W-1:0]  cmd_addr,
  input  logic [ADDR_W-1:0]  cmd_len,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [DATA_W-1:0]  live_in,
  input  logic [EVT_W-1:0]   evt_set,
  output logic [PULSE_W-1:0] pwr_pulse,
  input  logic               wdog_start,
  output logic [DATA_W-1:0]  wdog_limit,
  output logic               wdog_enable
);

  logic [ADDR_W-1:0] acc_addr;
  logic              acc_we;
  logic [DATA_W-1:0] acc_wdata;
  logic [DATA_W-1:0] fetch_byte;

  regbank_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .fetch_byte(fetch_byte)
  );

  regbank_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .POOL_DEPTH(POOL_DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .rst_wdog_cause(rst_wdog_cause),
    .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .rd_byte(fetch_byte), .live_in(live_in), .evt_set(evt_set),
    .pwr_pulse(pwr_pulse), .wdog_start(wdog_start),
    .wdog_limit(wdog_limit), .wdog_enable(wdog_enable)
  );

endmodule

// File: rtl/regbank_checker.sv
module regbank_checker
  import regbank_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_ready,
  input logic               wr_ready,
  input logic               rd_valid,
  input logic               rd_ready,
  input logic [DATA_W-1:0]  rd_data,
  input logic [PULSE_W-1:0] pwr_pulse,
  input logic               wdog_start,
  input logic [DATA_W-1:0]  wdog_limit
);

  // R3: a held read byte stays put until taken
  a_r3_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

  // R1: commands only taken with no burst and no pending byte
  a_r1_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rd_valid && !wr_ready);

  // R8: power pulses last a single cycle
  a_r8_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
    (|pwr_pulse) |=> (pwr_pulse == '0));

  // R10: working limit moves only on a start strobe
  a_r10_limit_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wdog_start |=> $stable(wdog_limit));

endmodule

bind regbank_top regbank_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .pwr_pulse(pwr_pulse), .wdog_start(wdog_start), .wdog_limit(wdog_limit)
);

// File: tb/regbank_top_bench.sv
`timescale 1ns/1ps
module regbank_top_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rst_wdog_cause = 1'b0;
  logic       cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [7:0] cmd_addr = '0, cmd_len = '0;
  logic       cmd_ready;
  logic       wr_valid = 1'b0, wr_ready;
  logic [7:0] wr_data = '0;
  logic       rd_valid, rd_ready = 1'b1;
  logic [7:0] rd_data;
  logic [7:0] live_in = 8'h3C;
  logic [1:0] evt_set = '0;
  logic [3:0] pwr_pulse;
  logic       wdog_start = 1'b0;
  logic [7:0] wdog_limit;
  logic       wdog_enable;

  int n_tests = 0;
  int n_fail  = 0;
  logic       bp_en = 1'b0;
  logic [7:0] lfsr = 8'hA7;

  logic [7:0] mmem [256];
  logic [1:0] mevt;
  logic [7:0] wbuf [256];
  logic [7:0] exp_q[$];
  int         tag_q[$];

  always #4 clk = ~clk;

  regbank_top u_regbank_top (.*);

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [7:0] a);
    if (a >= 8'h60)                 return 8'hFF;
    if (a == 8'h02)                 return {6'b0, mevt};
    if (a == 8'h20 || a == 8'h3D)   return 8'h00;
    if (a == 8'h27)                 return live_in;
    return mmem[a];
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a >= 8'h60 || a == 8'h20 || a == 8'h27) return;
    if (a == 8'h02) mevt = mevt & ~d[1:0];
    else            mmem[a] = d;
  endtask

  // random back-pressure, changed well after the rising edge
  always @(posedge clk) begin
    #2;
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ready = bp_en ? lfsr[0] : 1'b1;
  end

  // monitor: scoreboard compare and hold check
  logic       held = 1'b0;
  logic [7:0] held_data = '0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (held) begin
        check(3, {rd_valid, rd_data}, {1'b1, held_data}); // R3 hold
      end
      held = rd_valid && !rd_ready;
      held_data = rd_data;
      if (rd_valid && rd_ready) begin
        if (exp_q.size() == 0) begin
          check(1, rd_data, 32'hDEAD); // R1: unexpected byte
        end else begin
          check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
      end
    end else begin
      held = 1'b0;
    end
  end

  task automatic issue_cmd(input logic w, input logic [7:0] a, input logic [7:0] len);
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_len = len;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic do_write(input logic [7:0] a, input int n, input logic [1:0] set_first);
    logic [7:0] ad;
    issue_cmd(1'b1, a, 8'(n - 1));
    for (int i = 0; i < n; i++) begin
      ad = a + 8'(i);
      wr_valid = 1'b1; wr_data = wbuf[i];
      evt_set = (i == 0) ? set_first : 2'b00;
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      evt_set = 2'b00;
      model_write(ad, wbuf[i]);
      if (i == 0) mevt = mevt | set_first;
      // R8: pulse only after a beat to 0x20, low nibble only
      check(8, pwr_pulse, (ad == 8'h20) ? {28'b0, wbuf[i][3:0]} : 32'h0);
      if (i % 3 == 1) begin
        wr_valid = 1'b0;
        @(negedge clk);
      end
    end
    wr_valid = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] a, input int n, input int req);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(model_read(a + 8'(i)));
      tag_q.push_back(req);
    end
    issue_cmd(1'b0, a, 8'(n - 1));
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic cause);
    @(negedge clk);
    rst_n = 1'b0; rst_wdog_cause = cause;
    repeat (4) @(negedge clk);
    rst_n = 1'b1; rst_wdog_cause = 1'b0;
    for (int i = 0; i < 256; i++) mmem[i] = 8'h00;
    mevt = cause ? 2'b11 : 2'b00;
    // R7: idle outputs after reset
    check(7, {cmd_ready, rd_valid, wr_ready}, 3'b100);
    check(7, pwr_pulse, 0);
    check(7, wdog_limit, 0);
  endtask

  task automatic pulse_start();
    wdog_start = 1'b1;
    @(negedge clk);
    wdog_start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset(1'b0);
    do_read(8'h00, 6, 7);                       // R7: cleared pool, flags 0

    // R1 R3: plain burst write and readback
    for (int i = 0; i < 8; i++) wbuf[i] = 8'h10 + 8'(i * 7);
    do_write(8'h10, 8, 2'b00);
    do_read(8'h10, 8, 3);
    do_read(8'h12, 1, 1);

    // R4: burst runs past 0x5F into absent space
    for (int i = 0; i < 6; i++) wbuf[i] = 8'hA0 + 8'(i);
    do_write(8'h5C, 6, 2'b00);
    do_read(8'h5C, 6, 4);
    do_read(8'h00, 2, 4);                        // no alias of 0x60/0x61

    // R2: wrap from 0xFF to 0x00
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h5A; wbuf[3] = 8'hC3;
    do_write(8'hFE, 4, 2'b00);
    do_read(8'hFE, 4, 2);

    // R5: live read-only register
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
    do_write(8'h26, 3, 2'b00);
    do_read(8'h26, 3, 5);
    live_in = 8'h5A;
    do_read(8'h27, 1, 5);

    // R8 R9: pulse register and write-only store
    wbuf[0] = 8'h77; wbuf[1] = 8'hF6; wbuf[2] = 8'h88;
    do_write(8'h1F, 3, 2'b00);
    do_read(8'h1F, 3, 9);
    wbuf[0] = 8'hAB;
    do_write(8'h3D, 1, 2'b00);
    do_read(8'h3D, 1, 9);

    // R6: event flags set, acknowledge, upper bits
    evt_set = 2'b11; @(negedge clk); evt_set = 2'b00; mevt = 2'b11;
    do_read(8'h02, 1, 6);
    wbuf[0] = 8'h01; do_write(8'h02, 1, 2'b00);
    do_read(8'h02, 1, 6);
    wbuf[0] = 8'hFC; do_write(8'h02, 1, 2'b00);
    do_read(8'h02, 1, 6);
    wbuf[0] = 8'h02; do_write(8'h02, 1, 2'b00);
    do_read(8'h02, 1, 6);
    wbuf[0] = 8'h01; do_write(8'h02, 1, 2'b01); // set wins over ack
    do_read(8'h02, 1, 6);

    // R10: watchdog limit latched only on start
    wbuf[0] = 8'h40; do_write(8'h24, 1, 2'b00);
    check(10, wdog_limit, 0);
    pulse_start();
    check(10, {wdog_enable, wdog_limit}, {1'b1, 8'h40});
    wbuf[0] = 8'h00; do_write(8'h24, 1, 2'b00);
    check(10, {wdog_enable, wdog_limit}, {1'b1, 8'h40});
    pulse_start();
    check(10, {wdog_enable, wdog_limit}, {1'b0, 8'h00});

    // R3 R2: back-pressure over a full wrapping read
    bp_en = 1'b1;
    do_read(8'h10, 8, 3);
    do_read(8'h00, 256, 2);
    bp_en = 1'b0;
    @(negedge clk);

    // R7: watchdog-caused reset sets both flags
    do_reset(1'b1);
    do_read(8'h02, 1, 7);
    do_read(8'h10, 2, 7);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule